// File: doc/BRIEF.md
# Counter-Expanded Block-Cipher PRF Engine

This block is a keyed pseudorandom function. It takes a 128-bit secret key, a message of one or more 128-bit blocks and a requested output size in bits, and returns a stream of 128-bit blocks that depends on all three.

The engine is built around a SIMON 128/128 cipher core that runs one round per clock. It first chains the requested length and then every message block through the cipher, starting from an all-zero initial value, in the way a CBC-MAC does. The result is the absorbed state. It then encrypts that state XORed with a running counter, one output block per counter value.

Because the length enters the chain, two requests that share the key and the message but ask for different sizes give unrelated streams. A caller can use the stream as extracted key material or as an XOR keystream.

Top module: `prfEngine`

## Requirements
- R1: The cipher is SIMON with a 128-bit block, a 128-bit key and 68 rounds, with the round keys produced on the fly. Key bits [63:0] form the first schedule word and bits [127:64] the second. Block bits [127:64] are the left word. Under key 0f0e0d0c0b0a09080706050403020100, the block 63736564207372656c6c657661727420 encrypts to 49681b1e1e54fe3f65aa832af84e0bbc.
- R2: The absorbed state is computed in a fixed order. The engine first encrypts the length block, which holds the requested bit count in bits [15:0] and zeros elsewhere. It then XORs each message block, in arrival order, into the running value and encrypts the result.
- R3: Output block j, for j = 0, 1, 2, ..., is the encryption of the absorbed state XORed with j. The counter j is zero-extended and occupies bits [31:0]. Blocks leave in increasing j.
- R4: A request yields exactly ceil(bits/128) output blocks, after which the engine again waits for a new first block. A request of 0 bits yields no output block.
- R5: msgReady is high only while the engine waits for the first block of a request or for the next block of the current one. It is high after reset and never high together with outValid. msgValid has no effect while msgReady is low.
- R6: keyLoad takes effect only while the engine waits for the first block of a request. A key loaded in the same cycle as that block applies to the request. keyLoad is ignored at all other times.
- R7: While outValid is high and outReady is low, outValid and outData hold unchanged. No further encryption starts until the block is taken.
- R8: Each encryption takes 68 clock cycles. For a single-block request, outValid rises 208 cycles after the edge that accepts the block. Each later block arrives 70 cycles after the edge at which the previous one is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset, synchronous |
| keyLoad | input | 1 | Load keyIn as the secret key |
| keyIn | input | 128 | Secret key |
| outBits | input | LEN_W | Requested output size in bits, sampled with the first block |
| msgValid | input | 1 | Message block offered |
| msgData | input | 128 | Message block |
| msgLast | input | 1 | Marks the final message block |
| msgReady | output | 1 | Engine accepts a message block |
| outValid | output | 1 | Output block available |
| outData | output | 128 | Output block |
| outReady | input | 1 | Consumer takes the output block |

## Verification
The bench builds the engine with its default parameters: a 16-bit length field and a 32-bit counter. These values cover requests of zero bits, of exact multiples of 128 bits and of partial trailing blocks, up to three output blocks per request. The cipher is compared against an independent model that is itself anchored to the published 128/128 vector. A long stall on the output is held to expose hold-and-stall behaviour and the cycle counts.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int WORD_W  = 64;
  localparam int BLOCK_W = 2 * WORD_W;
  localparam int ROUNDS  = 68;
  localparam int ZLEN    = 62;
  localparam logic [ZLEN-1:0] ZSEQ =
    62'b10101111011100000011010010011000101000010001111110010110110011;

  typedef enum logic [1:0] {SRC_LEN, SRC_LIVE, SRC_PEND, SRC_CTR} blkSrc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEN_RUN, ST_MSG_RUN, ST_WAIT, ST_EXP_START, ST_EXP_RUN, ST_OUT
  } prfState_e;

  typedef struct packed {
    logic    keyWe;
    logic    capture;
    logic    capLen;
    logic    start;
    blkSrc_e src;
    logic    saveAbs;
    logic    ctrClr;
    logic    ctrInc;
  } ctrlStrobe_t;
endpackage

// File: rtl/simonRoundCore.sv
module simonRoundCore
  import prf_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int NROUND = ROUNDS
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [2*W-1:0] blockIn,
  input  logic [2*W-1:0] keyIn,
  output logic [2*W-1:0] blockOut,
  output logic           done
);
  localparam int RW = $clog2(NROUND + 1);

  logic [W-1:0]  xQ, yQ, kAQ, kBQ;
  logic [W-1:0]  fx, xNext, kTmp, kNext;
  logic [RW-1:0] rndQ;
  logic [5:0]    zIdx, zPos;
  logic          runQ, doneQ;

  function automatic logic [W-1:0] rol(input logic [W-1:0] v, input int s);
    return (v << s) | (v >> (W - s));
  endfunction

  function automatic logic [W-1:0] ror(input logic [W-1:0] v, input int s);
    return (v >> s) | (v << (W - s));
  endfunction

  always_comb begin
    fx    = (rol(xQ, 1) & rol(xQ, 8)) ^ rol(xQ, 2);
    xNext = yQ ^ fx ^ kAQ;
    zIdx  = (rndQ >= RW'(ZLEN)) ? 6'(rndQ - RW'(ZLEN)) : 6'(rndQ);
    zPos  = 6'(ZLEN - 1) - zIdx;
    kTmp  = ror(kBQ, 3) ^ ror(kBQ, 4);
    kNext = ~kAQ ^ W'(3) ^ W'(ZSEQ[zPos]) ^ kTmp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xQ <= '0; yQ <= '0; kAQ <= '0; kBQ <= '0;
      rndQ <= '0; runQ <= 1'b0; doneQ <= 1'b0;
    end else if (start) begin
      xQ    <= blockIn[2*W-1:W];
      yQ    <= blockIn[W-1:0];
      kAQ   <= keyIn[W-1:0];
      kBQ   <= keyIn[2*W-1:W];
      rndQ  <= '0;
      runQ  <= 1'b1;
      doneQ <= 1'b0;
    end else if (runQ) begin
      xQ    <= xNext;
      yQ    <= xQ;
      kAQ   <= kBQ;
      kBQ   <= kNext;
      rndQ  <= rndQ + RW'(1);
      runQ  <= (rndQ != RW'(NROUND - 1));
      doneQ <= (rndQ == RW'(NROUND - 1));
    end else begin
      doneQ <= 1'b0;
    end
  end

  assign blockOut = {xQ, yQ};
  assign done     = doneQ;
endmodule

// File: rtl/prfDatapath.sv
module prfDatapath
  import prf_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [BLOCK_W-1:0] keyIn,
  input  logic [LEN_W-1:0]   outBits,
  input  logic [BLOCK_W-1:0] msgData,
  input  logic               msgLast,
  output logic [BLOCK_W-1:0] outData,
  output logic               cipherDone,
  output logic               pendLast,
  output logic               noOutput,
  output logic               finalBlock
);
  localparam int NEED_W = LEN_W - 6;

  logic [BLOCK_W-1:0] keyQ, keyUse, pendQ, absQ, blkIn, cOut;
  logic [LEN_W-1:0]   lenQ;
  logic [CTR_W-1:0]   ctrQ;
  logic [NEED_W-1:0]  needBlocks;
  logic               lastQ;

  assign keyUse     = strb.keyWe ? keyIn : keyQ;
  assign needBlocks = {1'b0, lenQ[LEN_W-1:7]} + NEED_W'(|lenQ[6:0]);
  assign noOutput   = (needBlocks == '0);
  assign finalBlock = (ctrQ + CTR_W'(1)) == CTR_W'(needBlocks);
  assign pendLast   = lastQ;

  always_comb begin
    unique case (strb.src)
      SRC_LEN:  blkIn = BLOCK_W'(outBits);
      SRC_LIVE: blkIn = cOut ^ msgData;
      SRC_PEND: blkIn = cOut ^ pendQ;
      default:  blkIn = absQ ^ BLOCK_W'(ctrQ);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyQ <= '0; pendQ <= '0; absQ <= '0; lenQ <= '0; ctrQ <= '0; lastQ <= 1'b0;
    end else begin
      if (strb.keyWe)   keyQ <= keyIn;
      if (strb.capture) begin
        pendQ <= msgData;
        lastQ <= msgLast;
      end
      if (strb.capLen)  lenQ <= outBits;
      if (strb.saveAbs) absQ <= cOut;
      if (strb.ctrClr)      ctrQ <= '0;
      else if (strb.ctrInc) ctrQ <= ctrQ + CTR_W'(1);
    end
  end

  simonRoundCore #(.W(WORD_W), .NROUND(ROUNDS)) uCore (
    .clk      (clk),
    .rstN     (rstN),
    .start    (strb.start),
    .blockIn  (blkIn),
    .keyIn    (keyUse),
    .blockOut (cOut),
    .done     (cipherDone)
  );

  assign outData = cOut;
endmodule

// File: rtl/prfControl.sv
module prfControl
  import prf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        keyLoad,
  input  logic        msgValid,
  input  logic        outReady,
  input  logic        cipherDone,
  input  logic        pendLast,
  input  logic        noOutput,
  input  logic        finalBlock,
  output ctrlStrobe_t strb,
  output logic        msgReady,
  output logic        outValid
);
  prfState_e stateQ, stateD;

  always_comb begin
    strb     = '0;
    msgReady = 1'b0;
    outValid = 1'b0;
    stateD   = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        msgReady   = 1'b1;
        strb.keyWe = keyLoad;
        if (msgValid) begin
          strb.capture = 1'b1;
          strb.capLen  = 1'b1;
          strb.start   = 1'b1;
          strb.src     = SRC_LEN;
          stateD       = ST_LEN_RUN;
        end
      end
      ST_LEN_RUN: if (cipherDone) begin
        strb.start = 1'b1;
        strb.src   = SRC_PEND;
        stateD     = ST_MSG_RUN;
      end
      ST_MSG_RUN: if (cipherDone) begin
        if (pendLast) begin
          strb.saveAbs = 1'b1;
          strb.ctrClr  = 1'b1;
          stateD       = noOutput ? ST_IDLE : ST_EXP_START;
        end else begin
          stateD = ST_WAIT;
        end
      end
      ST_WAIT: begin
        msgReady = 1'b1;
        if (msgValid) begin
          strb.capture = 1'b1;
          strb.start   = 1'b1;
          strb.src     = SRC_LIVE;
          stateD       = ST_MSG_RUN;
        end
      end
      ST_EXP_START: begin
        strb.start = 1'b1;
        strb.src   = SRC_CTR;
        stateD     = ST_EXP_RUN;
      end
      ST_EXP_RUN: if (cipherDone) stateD = ST_OUT;
      default: begin
        outValid = 1'b1;
        if (outReady) begin
          if (finalBlock) stateD = ST_IDLE;
          else begin
            strb.ctrInc = 1'b1;
            stateD      = ST_EXP_START;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/prfEngine.sv
module prfEngine
  import prf_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               keyLoad,
  input  logic [BLOCK_W-1:0] keyIn,
  input  logic [LEN_W-1:0]   outBits,
  input  logic               msgValid,
  input  logic [BLOCK_W-1:0] msgData,
  input  logic               msgLast,
  output logic               msgReady,
  output logic               outValid,
  output logic [BLOCK_W-1:0] outData,
  input  logic               outReady
);
  ctrlStrobe_t strb;
  logic cipherDone, pendLast, noOutput, finalBlock;

  prfControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .keyLoad    (keyLoad),
    .msgValid   (msgValid),
    .outReady   (outReady),
    .cipherDone (cipherDone),
    .pendLast   (pendLast),
    .noOutput   (noOutput),
    .finalBlock (finalBlock),
    .strb       (strb),
    .msgReady   (msgReady),
    .outValid   (outValid)
  );

  prfDatapath #(.LEN_W(LEN_W), .CTR_W(CTR_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .keyIn      (keyIn),
    .outBits    (outBits),
    .msgData    (msgData),
    .msgLast    (msgLast),
    .outData    (outData),
    .cipherDone (cipherDone),
    .pendLast   (pendLast),
    .noOutput   (noOutput),
    .finalBlock (finalBlock)
  );
endmodule

// File: rtl/prfEngineChecker.sv
module prfEngineChecker (
  input logic         clk,
  input logic         rstN,
  input logic         msgValid,
  input logic         msgReady,
  input logic         outValid,
  input logic         outReady,
  input logic [127:0] outData
);
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  assert_ready_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(msgReady && outValid));

  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgReady |=> !msgReady);

  assert_gap_after_take_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady |=> !outValid);
endmodule

bind prfEngine prfEngineChecker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .msgValid (msgValid),
  .msgReady (msgReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/sim_prfEngine.sv
module sim_prfEngine;
  localparam int CLK_PERIOD = 10;
  localparam logic [61:0] ZREF =
    62'b10101111011100000011010010011000101000010001111110010110110011;

  typedef struct packed {
    logic [127:0] key;
    logic [127:0] m0;
    logic [127:0] m1;
    logic [1:0]   nMsg;
    logic [15:0]  bits;
  } vec_t;

  localparam logic [127:0] KEY_A = 128'h0f0e0d0c0b0a09080706050403020100;
  localparam logic [127:0] MSG_A = 128'h63736564207372656c6c657661727420;

  localparam vec_t VECS [4] = '{
    '{KEY_A, MSG_A, 128'h0, 2'd1, 16'd128},
    '{128'h00112233445566778899aabbccddeeff, 128'h1, 128'hdeadbeef00000000cafef00d12345678, 2'd2, 16'd256},
    '{128'hffffffffffffffff0000000000000000, 128'h0, 128'hffffffffffffffffffffffffffffffff, 2'd2, 16'd300},
    '{KEY_A, MSG_A, 128'h0, 2'd1, 16'd129}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic keyLoad = 1'b0, msgValid = 1'b0, msgLast = 1'b0, outReady = 1'b1;
  logic [127:0] keyIn = '0, msgData = '0;
  logic [15:0]  outBits = '0;
  logic msgReady, outValid;
  logic [127:0] outData;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [127:0] firstOut [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  prfEngine u0 (
    .clk(clk), .rstN(rstN), .keyLoad(keyLoad), .keyIn(keyIn), .outBits(outBits),
    .msgValid(msgValid), .msgData(msgData), .msgLast(msgLast), .msgReady(msgReady),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  function automatic logic [63:0] rl(input logic [63:0] v, input int s);
    return (v << s) | (v >> (64 - s));
  endfunction

  function automatic logic [63:0] rr(input logic [63:0] v, input int s);
    return (v >> s) | (v << (64 - s));
  endfunction

  function automatic logic [127:0] simonEnc(input logic [127:0] k, input logic [127:0] p);
    logic [63:0] x, y, a, b, t, nb;
    x = p[127:64]; y = p[63:0]; a = k[63:0]; b = k[127:64];
    for (int i = 0; i < 68; i++) begin
      t  = x;
      x  = y ^ ((rl(x, 1) & rl(x, 8)) ^ rl(x, 2)) ^ a;
      y  = t;
      nb = ~a ^ 64'd3 ^ {63'd0, ZREF[61 - (i % 62)]} ^ rr(b, 3) ^ rr(b, 4);
      a  = b;
      b  = nb;
    end
    return {x, y};
  endfunction

  function automatic logic [127:0] expectBlk(input vec_t v, input int j);
    logic [127:0] s;
    s = simonEnc(v.key, {112'd0, v.bits});
    s = simonEnc(v.key, s ^ v.m0);
    if (v.nMsg == 2'd2) s = simonEnc(v.key, s ^ v.m1);
    return simonEnc(v.key, s ^ {96'd0, 32'(j)});
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadKey(input logic [127:0] k);
    @(negedge clk);
    keyLoad = 1'b1; keyIn = k;
    @(posedge clk); #1;
    keyLoad = 1'b0;
  endtask

  task automatic sendBlock(input logic [127:0] d, input logic last, input logic [15:0] bits);
    @(negedge clk);
    msgValid = 1'b1; msgData = d; msgLast = last; outBits = bits;
    while (!msgReady) @(negedge clk);
    @(posedge clk); #1;
    msgValid = 1'b0;
  endtask

  task automatic recvBlock(output logic [127:0] d);
    @(negedge clk);
    while (!outValid) @(negedge clk);
    d = outData;
    @(posedge clk); #1;
  endtask

  task automatic countToValid(output int n);
    n = 0;
    while (!outValid) begin
      @(posedge clk); n++; #1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [127:0] got, held;
    vec_t v;
    int n;
    bit bad;

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    // R5: reset state
    chk(msgReady == 1'b1, "R5 ready after reset", 128'(msgReady), 128'd1);
    chk(outValid == 1'b0, "R5 no output after reset", 128'(outValid), 128'd0);

    // R1: reference model anchored to the published vector
    got = simonEnc(KEY_A, MSG_A);
    chk(got == 128'h49681b1e1e54fe3f65aa832af84e0bbc, "R1 cipher vector", got,
        128'h49681b1e1e54fe3f65aa832af84e0bbc);

    // R2 R3 R4: vector table
    for (int i = 0; i < 4; i++) begin
      v = VECS[i];
      loadKey(v.key);
      sendBlock(v.m0, v.nMsg == 2'd1, v.bits);
      if (v.nMsg == 2'd2) sendBlock(v.m1, 1'b1, v.bits);
      for (int j = 0; j < (int'(v.bits) + 127) / 128; j++) begin
        recvBlock(got);
        if (j == 0) firstOut[i] = got;
        chk(got == expectBlk(v, j), $sformatf("R3 vec%0d block%0d", i, j), got, expectBlk(v, j));
      end
      @(negedge clk);
      chk(msgReady && !outValid, $sformatf("R4 vec%0d idle after count", i),
          {126'd0, msgReady, outValid}, 128'd2);
    end
    // R2: length is bound into the chain
    chk(firstOut[0] != firstOut[3], "R2 length changes stream", firstOut[3], ~firstOut[0]);

    // R4: zero-length request gives nothing
    sendBlock(MSG_A, 1'b1, 16'd0);
    bad = 1'b0;
    repeat (250) begin
      @(negedge clk);
      if (outValid) bad = 1'b1;
    end
    chk(!bad, "R4 zero bits no output", 128'(bad), 128'd0);
    chk(msgReady, "R4 zero bits back to ready", 128'(msgReady), 128'd1);

    // R6 + R5: key load and message offers while busy are ignored
    loadKey(KEY_A);
    sendBlock(MSG_A, 1'b1, 16'd128);
    repeat (20) @(negedge clk);
    keyLoad = 1'b1; keyIn = ~KEY_A; msgValid = 1'b1; msgData = '1; msgLast = 1'b1;
    chk(!msgReady, "R5 ready low while busy", 128'(msgReady), 128'd0);
    repeat (5) @(negedge clk);
    keyLoad = 1'b0; msgValid = 1'b0;
    recvBlock(got);
    chk(got == expectBlk(VECS[0], 0), "R6 busy key ignored", got, expectBlk(VECS[0], 0));
    sendBlock(MSG_A, 1'b1, 16'd128);
    recvBlock(got);
    chk(got == expectBlk(VECS[0], 0), "R6 key retained next run", got, expectBlk(VECS[0], 0));

    // R7 + R8: backpressure and cycle counts
    v = '{KEY_A, MSG_A, 128'h0, 2'd1, 16'd256};
    outReady = 1'b0;
    sendBlock(MSG_A, 1'b1, 16'd256);
    countToValid(n);
    chk(n == 208, "R8 first block latency", 128'(n), 128'd208);
    held = outData;
    chk(held == expectBlk(v, 0), "R3 stalled block0", held, expectBlk(v, 0));
    bad = 1'b0;
    repeat (100) begin
      @(negedge clk);
      if (!outValid || outData != held || msgReady) bad = 1'b1;
    end
    chk(!bad, "R7 output held under stall", 128'(bad), 128'd0);
    @(negedge clk) outReady = 1'b1;
    @(posedge clk); #1;
    outReady = 1'b0;
    countToValid(n);
    chk(n == 70, "R8 block spacing", 128'(n), 128'd70);
    chk(outData == expectBlk(v, 1), "R3 stalled block1", outData, expectBlk(v, 1));
    @(negedge clk) outReady = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chk(msgReady && !outValid, "R4 two blocks then idle", {126'd0, msgReady, outValid}, 128'd2);

    finishRun();
  end
endmodule